// File: doc/BRIEF.md
# Word-Synchronous Serial Flag Unit

This block gives a serial audio transmitter and receiver a small set of side-channel flag pins whose values travel with the data words. The default is three pins. Each pin has a mode bit. A pin in input mode is not driven. Its level is captured in the same cycle as the first bit of a received word. The captured level becomes visible to software only when that word is handed to the receive data register. A pin in output mode is driven from a double-buffered flag register. Software fills the buffer ahead of time. The pin takes the new value only when the next transmit word is moved from the transmit data register into the shift register.

Two small state machines do the sequencing. The receive side has the states RX_IDLE (no word captured) and RX_HELD (a capture is waiting for delivery). It moves from RX_IDLE to RX_HELD on a first-bit strobe. It returns to RX_IDLE on a delivery strobe, unless a new first bit arrives in the same cycle, in which case it stays in RX_HELD. The transmit side has the states TX_EMPTY (transmit data register consumed) and TX_FULL (data waiting). It moves from TX_EMPTY to TX_FULL on a data-register write. It moves from TX_FULL back to TX_EMPTY on a shift-register load, unless a new write arrives in the same cycle. Only the TX_FULL-to-load event copies the flag buffer to the pins.

The register port has three locations. Select 0 holds the mode bits. Select 1 holds the flag buffer. Select 2 is a read-only status word. Reads are combinational.

Top module: `wsf_flag_unit`

## Requirements
- R1: After reset, the captured input flags, the flag buffer, the driven pin values and all mode bits are 0. The transmit-empty status is 1, so status reads 4'b1000.
- R2: Mode bit i (select 0, bit i; 1 = output) drives pin_oe[i] from the cycle after the write. A pin in input mode (mode 0) has pin_oe low. Reading select 0 returns {1'b0, mode}.
- R3: In the cycle rx_first is high, the unit latches pin_in, all pins regardless of mode. Later changes on pin_in do not alter the latched value.
- R4: The status bits [2:0] (input flags) change only on an rx_xfer that follows a capture. They then take the latched value. An rx_xfer with no capture pending has no effect.
- R5: A write to the flag buffer (select 1) does not change pin_out by itself.
- R6: A tx_load while transmit data is pending copies the flag buffer to pin_out at that edge. pin_out then holds until the next such load.
- R7: If the flag buffer is written several times before a load, only the last value reaches the pins. Reading select 1 returns {1'b0, buffer}.
- R8: Status bit 3 (transmit empty) is set by a tx_load that consumes pending data. It is cleared by txd_wr. A txd_wr in the same cycle as a consuming load leaves the unit full. A tx_load while empty leaves pin_out unchanged.
- R9: Writes to select 2 or select 3 change no register. Reading select 3 returns 0.
- R10: An rx_first while a capture is pending replaces the capture. An rx_xfer in the same cycle as an rx_first delivers the older capture and keeps the new one pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | NFLAG | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | NFLAG+1 | Read data |
| rx_first | input | 1 | First bit of a received word is sampled |
| rx_xfer | input | 1 | Received word moves to the receive data register |
| txd_wr | input | 1 | Write to the transmit data register |
| tx_load | input | 1 | Transmit data register moves to the shift register |
| pin_in | input | NFLAG | Flag pin levels seen at the pads |
| pin_out | output | NFLAG | Flag pin drive values |
| pin_oe | output | NFLAG | Per-pin output enable |

## Verification
The receive path is driven with pin levels that change between capture and delivery. This separates a true latch from a transparent path. Back-to-back first-bit strobes with no delivery between them, and a first-bit strobe coinciding with a delivery, show whether the older or the newer capture is delivered. The transmit path is given repeated buffer writes, a load while empty, a load with data pending, and a load coinciding with a data write. These separate a pin update gated by pending data from one tied to the buffer write or to every load. Writes to the read-only and reserved selects confirm that no register is disturbed.

// File: rtl/wsf_pkg.sv
package wsf_pkg;
    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_OFLAG = 2'd1,
        SEL_STAT  = 2'd2,
        SEL_RSVD  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_HELD = 1'b1
    } rx_state_e;

    typedef enum logic {
        TX_EMPTY = 1'b0,
        TX_FULL  = 1'b1
    } tx_state_e;
endpackage

// File: rtl/wsf_rx_capture.sv
module wsf_rx_capture
    import wsf_pkg::*;
#(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_first,
    input  logic         rx_xfer,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] if_bits
);
    rx_state_e    state_q, state_d;
    logic [N-1:0] cap_q;
    logic         deliver;

    // A delivery only counts when a capture is pending.
    assign deliver = (state_q == RX_HELD) && rx_xfer;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (rx_first) state_d = RX_HELD;
            RX_HELD: if (rx_xfer && !rx_first) state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q   <= '0;
            if_bits <= '0;
        end else begin
            if (deliver)  if_bits <= cap_q;
            if (rx_first) cap_q   <= pin_in;
        end
    end
endmodule

// File: rtl/wsf_tx_apply.sv
module wsf_tx_apply
    import wsf_pkg::*;
#(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         txd_wr,
    input  logic         tx_load,
    input  logic [N-1:0] of_buf,
    output logic [N-1:0] pin_out,
    output logic         tx_empty
);
    tx_state_e state_q, state_d;
    logic      consume;

    assign consume = (state_q == TX_FULL) && tx_load;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_EMPTY: if (txd_wr) state_d = TX_FULL;
            TX_FULL:  if (tx_load && !txd_wr) state_d = TX_EMPTY;
            default:  state_d = TX_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       pin_out <= '0;
        else if (consume) pin_out <= of_buf;
    end

    assign tx_empty = (state_q == TX_EMPTY);
endmodule

// File: rtl/wsf_flag_unit.sv
module wsf_flag_unit
    import wsf_pkg::*;
#(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [NFLAG-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [NFLAG:0]   rd_data,
    input  logic             rx_first,
    input  logic             rx_xfer,
    input  logic             txd_wr,
    input  logic             tx_load,
    input  logic [NFLAG-1:0] pin_in,
    output logic [NFLAG-1:0] pin_out,
    output logic [NFLAG-1:0] pin_oe
);
    logic [NFLAG-1:0] mode_q;
    logic [NFLAG-1:0] of_buf_q;
    logic [NFLAG-1:0] if_bits;
    logic             tx_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            of_buf_q <= '0;
        end else if (wr_en) begin
            if (reg_sel_e'(wr_sel) == SEL_MODE)  mode_q   <= wr_data;
            if (reg_sel_e'(wr_sel) == SEL_OFLAG) of_buf_q <= wr_data;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_MODE:  rd_data = {1'b0, mode_q};
            SEL_OFLAG: rd_data = {1'b0, of_buf_q};
            SEL_STAT:  rd_data = {tx_empty, if_bits};
            default:   rd_data = '0;
        endcase
    end

    assign pin_oe = mode_q;

    wsf_rx_capture #(.N(NFLAG)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_first (rx_first),
        .rx_xfer  (rx_xfer),
        .pin_in   (pin_in),
        .if_bits  (if_bits)
    );

    wsf_tx_apply #(.N(NFLAG)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .txd_wr   (txd_wr),
        .tx_load  (tx_load),
        .of_buf   (of_buf_q),
        .pin_out  (pin_out),
        .tx_empty (tx_empty)
    );
endmodule

// File: rtl/wsf_flag_checker.sv
module wsf_flag_checker #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic [N-1:0] wr_data,
    input logic         rx_xfer,
    input logic         txd_wr,
    input logic         tx_load,
    input logic [N-1:0] pin_out,
    input logic [N-1:0] pin_oe,
    input logic         tx_empty,
    input logic [N-1:0] if_bits
);
    AST_OE_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (pin_oe == $past(wr_data))); // R2

    AST_IF_ONLY_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_xfer |=> $stable(if_bits)); // R4

    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_load |=> $stable(pin_out)); // R6

    AST_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        txd_wr |=> !tx_empty); // R8

    AST_EMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !tx_empty && !txd_wr) |=> tx_empty); // R8
endmodule

bind wsf_flag_unit wsf_flag_checker #(.N(NFLAG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rx_xfer  (rx_xfer),
    .txd_wr   (txd_wr),
    .tx_load  (tx_load),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .tx_empty (tx_empty),
    .if_bits  (if_bits)
);

// File: tb/sim_wsf_flag_unit.sv
module sim_wsf_flag_unit;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = '0;
    logic [N-1:0] wr_data = '0;
    logic [1:0]   rd_sel = '0;
    logic [N:0]   rd_data;
    logic         rx_first = 1'b0;
    logic         rx_xfer = 1'b0;
    logic         txd_wr = 1'b0;
    logic         tx_load = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out;
    logic [N-1:0] pin_oe;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        int         kind;   // 0 = rd_data, 1 = pin_out, 2 = pin_oe
        logic [N:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;   // 250 MHz

    wsf_flag_unit #(.NFLAG(N)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .rx_first(rx_first), .rx_xfer(rx_xfer), .txd_wr(txd_wr),
        .tx_load(tx_load), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Monitor: compares queued expectations at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [N:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = rd_data;
                1:       act = {1'b0, pin_out};
                default: act = {1'b0, pin_oe};
            endcase
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
        wr_en = 0; txd_wr = 0; tx_load = 0; rx_first = 0; rx_xfer = 0;
    endtask

    task automatic chk(input int kind, input logic [1:0] sel,
                       input logic [N:0] exp, input string tag);
        item_t it;
        rd_sel = sel;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        cyc();
    endtask

    task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        cyc();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk(0, 2'd2, 4'b1000, "R1 status");
        chk(0, 2'd1, 4'b0000, "R1 flag buffer");
        chk(0, 2'd0, 4'b0000, "R1 mode");
        chk(2, 2'd0, 4'b0000, "R1 pin_oe");
        chk(1, 2'd0, 4'b0000, "R1 pin_out");
        // R2 mode bits
        wr(2'd0, 3'b101);
        chk(2, 2'd0, 4'b0101, "R2 pin_oe after mode write");
        chk(0, 2'd0, 4'b0101, "R2 mode readback");
        // R3 / R4 capture then delivery
        pin_in = 3'b110; rx_first = 1; cyc();
        pin_in = 3'b001;
        chk(0, 2'd2, 4'b1000, "R4 no delivery before xfer");
        rx_xfer = 1; cyc();
        chk(0, 2'd2, 4'b1110, "R3 latched level delivered");
        pin_in = 3'b011; rx_xfer = 1; cyc();
        chk(0, 2'd2, 4'b1110, "R4 xfer without capture ignored");
        // R10 overrun and coincident strobes
        pin_in = 3'b011; rx_first = 1; cyc();
        pin_in = 3'b100; rx_first = 1; cyc();
        rx_xfer = 1; cyc();
        chk(0, 2'd2, 4'b1100, "R10 recapture replaces");
        pin_in = 3'b010; rx_first = 1; cyc();
        pin_in = 3'b111; rx_first = 1; rx_xfer = 1; cyc();
        chk(0, 2'd2, 4'b1010, "R10 coincident delivers older");
        rx_xfer = 1; cyc();
        chk(0, 2'd2, 4'b1111, "R10 newer stays pending");
        // R5 / R7 buffer writes
        wr(2'd1, 3'b011);
        chk(1, 2'd0, 4'b0000, "R5 buffer write not on pins");
        wr(2'd1, 3'b110);
        chk(0, 2'd1, 4'b0110, "R7 buffer readback");
        // R8 load while empty
        tx_load = 1; cyc();
        chk(1, 2'd0, 4'b0000, "R8 load while empty");
        txd_wr = 1; cyc();
        chk(0, 2'd2, 4'b0111, "R8 empty cleared by write");
        tx_load = 1; cyc();
        chk(1, 2'd0, 4'b0110, "R6 R7 last buffer on pins");
        chk(0, 2'd2, 4'b1111, "R8 empty set by load");
        wr(2'd1, 3'b001);
        cyc(); cyc();
        chk(1, 2'd0, 4'b0110, "R6 pins hold");
        txd_wr = 1; cyc();
        txd_wr = 1; tx_load = 1; cyc();
        chk(1, 2'd0, 4'b0001, "R6 second load applies");
        chk(0, 2'd2, 4'b0111, "R8 write with load stays full");
        tx_load = 1; cyc();
        chk(0, 2'd2, 4'b1111, "R8 drained");
        // R9 read-only and reserved selects
        wr(2'd2, 3'b000);
        wr(2'd3, 3'b010);
        chk(0, 2'd2, 4'b1111, "R9 status unchanged");
        chk(0, 2'd1, 4'b0001, "R9 buffer unchanged");
        chk(0, 2'd0, 4'b0101, "R9 mode unchanged");
        chk(0, 2'd3, 4'b0000, "R9 reserved reads zero");
        // R2 back to input mode
        wr(2'd0, 3'b000);
        chk(2, 2'd0, 4'b0000, "R2 input mode no drive");
        cyc();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule